// File: doc/BRIEF.md
# Multi-word command register sequencer

The sequencer sits behind two 32-bit write-only registers of a host-facing register file: a command register and a command-data register. A write to the command register picks an opcode and opens a fresh collection. Each write to the data register appends one word to a small buffer. Once the words for the chosen opcode are in, the block issues a single-cycle execute strobe. The strobe carries the opcode, the buffered words and the word count. In the same cycle the block loads that opcode's result code into a readable status register, then drops back to the unknown-command selection.

Each opcode has its own data length, and a zero-length opcode runs as soon as it is written. Any value outside the valid opcode window routes to an unknown-command handler, which needs no data and always fails. The block does not carry out the commands themselves. It only reports the result code that each command kind returns. All accesses are whole 32-bit words, and no byte enables exist. Every output is registered, so a write sampled on one clock edge is visible right after that edge.

Top module: `cmd_seq`

## Requirements
- R1: After reset, cmdStatus is 0 (success), execValid is 0 and overflow is 0.
- R2: A command write whose 32-bit value lies strictly between 0 and 10 selects that opcode. Any other value (0, 10, anything above 10) selects opcode 0, the unknown handler. Opcode 0 needs no data, so it executes at once with execOp 0 and status 1.
- R3: A command write for an opcode that needs data sets cmdStatus to 32'hFFFFFFFF (not enough data) and restarts the word count at zero. Words collected for an earlier, unfinished command are discarded.
- R4: Opcodes 2, 3, 6 and 8 need no data. They execute on the edge that samples their command write, with execCount 0.
- R5: Data words fill the buffer in write order. The command executes on the edge that samples its last required word. At that point, word i of execWords (bits 32*i+31 down to 32*i) holds the i-th data word written since the command write, and execCount equals the required length.
- R6: The required data lengths are: opcode 1 needs 6 words, 4 needs 12, 5 needs 3, 7 needs 4 and 9 needs 4.
- R7: On execution, cmdStatus becomes 1 (failed) for opcodes 0, 1, 2 and 3, and 0 (succeeded) for opcodes 4 to 9.
- R8: After any execution the selection is opcode 0. A data write with no command write before it therefore executes opcode 0 with execCount 1 and status 1.
- R9: When a command write and a data write fall in the same cycle, the command write takes effect and the data word is ignored.
- R10: execValid is high for exactly one cycle per execution. It is high only in the cycle after a command or data write.
- R11: The overflow output never rises. Every command executes no later than its last buffer slot, so a data write never meets a full buffer. Such a write would be dropped and would set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrCmd | input | 1 | Write strobe for the command register |
| wrDat | input | 1 | Write strobe for the command-data register |
| wrData | input | 32 | Write value shared by both registers |
| cmdStatus | output | 32 | Command status register read value |
| execValid | output | 1 | One-cycle execute strobe |
| execOp | output | 4 | Opcode being executed |
| execWords | output | 384 | Buffered data words, word i at bits 32*i+31:32*i |
| execCount | output | 4 | Number of data words collected for this execution |
| overflow | output | 1 | Sticky flag: a data word arrived at a full buffer |

## Verification
The assertions assume that every write strobe is a synchronous one-cycle pulse. They also assume that wrData is stable and meaningful only while a strobe is high. The bench raises at most one strobe per cycle, with one deliberate exception: the collision case, which pairs both strobes to check their priority. Inputs change on the falling edge, which keeps them clear of the sampling edge. The pattern of sequences covers zero-length opcodes, every data-carrying length, out-of-range opcode values, restarted collections and stray data writes. None of these can fill the buffer, so the no-overflow property is expected to hold throughout.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int WORD_W     = 32;
  localparam int RING_WORDS = 12;
  localparam int BUF_DEPTH  = RING_WORDS;
  localparam int CNT_W      = $clog2(BUF_DEPTH + 1);
  localparam int OP_W       = 4;

  typedef enum logic [OP_W-1:0] {
    OP_UNKNOWN  = 4'd0,
    OP_CONFIG   = 4'd1,
    OP_ISSUE    = 4'd2,
    OP_UNPLUG   = 4'd3,
    OP_RINGS    = 4'd4,
    OP_DEV_RST  = 4'd5,
    OP_BUS_RST  = 4'd6,
    OP_MSG_RING = 4'd7,
    OP_ADP_RST  = 4'd8,
    OP_ABORT    = 4'd9,
    OP_LAST     = 4'd10
  } opcode_e;

  localparam logic [WORD_W-1:0] ST_OK    = '0;
  localparam logic [WORD_W-1:0] ST_FAIL  = WORD_W'(1);
  localparam logic [WORD_W-1:0] ST_SHORT = '1;

  typedef struct packed {
    logic             pend;   // opcode accepted, awaiting data
    logic             store;  // write data word into buffer slot idx
    logic [CNT_W-1:0] idx;
    logic             fire;   // execute now
    opcode_e          op;
    logic [CNT_W-1:0] count;  // words collected at fire
    logic             ovf;    // data word met a full buffer
  } strobe_t;

  function automatic opcode_e decode_op(logic [WORD_W-1:0] v);
    if (v > 0 && v < WORD_W'(OP_LAST)) return opcode_e'(v[OP_W-1:0]);
    return OP_UNKNOWN;
  endfunction

  function automatic logic [CNT_W-1:0] need_words(opcode_e op);
    case (op)
      OP_CONFIG:   return CNT_W'(6);
      OP_RINGS:    return CNT_W'(RING_WORDS);
      OP_DEV_RST:  return CNT_W'(3);
      OP_MSG_RING: return CNT_W'(4);
      OP_ABORT:    return CNT_W'(4);
      default:     return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] result_of(opcode_e op);
    case (op)
      OP_UNKNOWN, OP_CONFIG, OP_ISSUE, OP_UNPLUG: return ST_FAIL;
      default:                                    return ST_OK;
    endcase
  endfunction
endpackage

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
  import cmd_seq_pkg::*;
#(
  parameter int WordW = WORD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCmd,
  input  logic             wrDat,
  input  logic [WordW-1:0] wrData,
  output strobe_t          strb
);
  opcode_e          curOp;
  logic [CNT_W-1:0] cnt;
  opcode_e          newOp;
  logic             bufFull;
  logic [CNT_W:0]   cntNext;

  assign newOp   = decode_op(WORD_W'(wrData));
  assign bufFull = (cnt == CNT_W'(BUF_DEPTH));
  assign cntNext = {1'b0, cnt} + 1'b1;

  always_comb begin
    strb = '0;
    strb.op = OP_UNKNOWN;
    if (wrCmd) begin
      if (need_words(newOp) == '0) begin
        strb.fire = 1'b1;
        strb.op   = newOp;
      end else begin
        strb.pend = 1'b1;
      end
    end else if (wrDat) begin
      if (bufFull) begin
        strb.ovf = 1'b1;
      end else begin
        strb.store = 1'b1;
        strb.idx   = cnt;
        if (cntNext >= {1'b0, need_words(curOp)}) begin
          strb.fire  = 1'b1;
          strb.op    = curOp;
          strb.count = cntNext[CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOp <= OP_UNKNOWN;
      cnt   <= '0;
    end else if (wrCmd) begin
      curOp <= strb.fire ? OP_UNKNOWN : newOp;
      cnt   <= '0;
    end else if (wrDat && !bufFull) begin
      if (strb.fire) begin
        curOp <= OP_UNKNOWN;
        cnt   <= '0;
      end else begin
        cnt <= cntNext[CNT_W-1:0];
      end
    end
  end

  // R11: collection never reaches a full buffer
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(BUF_DEPTH));

  // R8: after an execution the sequencer is idle on the unknown opcode
  a_r8_idle_after_fire: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> (curOp == OP_UNKNOWN && cnt == '0));
endmodule

// File: rtl/cmd_seq_data.sv
module cmd_seq_data
  import cmd_seq_pkg::*;
#(
  parameter int WordW = WORD_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [WordW-1:0]           wrData,
  input  strobe_t                    strb,
  output logic [WordW-1:0]           cmdStatus,
  output logic                       execValid,
  output logic [OP_W-1:0]            execOp,
  output logic [BUF_DEPTH*WordW-1:0] execWords,
  output logic [CNT_W-1:0]           execCount,
  output logic                       overflow
);
  logic [WordW-1:0] wordBuf [BUF_DEPTH];

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) wordBuf[g] <= '0;
      else if (strb.store && strb.idx == CNT_W'(g)) wordBuf[g] <= wrData;
    end
    assign execWords[g*WordW +: WordW] = wordBuf[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStatus <= WordW'(ST_OK);
      execValid <= 1'b0;
      execOp    <= '0;
      execCount <= '0;
      overflow  <= 1'b0;
    end else begin
      execValid <= strb.fire;
      overflow  <= overflow | strb.ovf;
      if (strb.fire) begin
        cmdStatus <= WordW'(result_of(strb.op));
        execOp    <= strb.op;
        execCount <= strb.count;
      end else if (strb.pend) begin
        cmdStatus <= WordW'(ST_SHORT);
      end
    end
  end

  // R7: failing handlers report status 1
  a_r7_fail_codes: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && execOp <= OP_W'(3)) |-> cmdStatus == WordW'(ST_FAIL));
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import cmd_seq_pkg::*;
#(
  parameter int WordW = WORD_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrCmd,
  input  logic                       wrDat,
  input  logic [WordW-1:0]           wrData,
  output logic [WordW-1:0]           cmdStatus,
  output logic                       execValid,
  output logic [OP_W-1:0]            execOp,
  output logic [BUF_DEPTH*WordW-1:0] execWords,
  output logic [CNT_W-1:0]           execCount,
  output logic                       overflow
);
  strobe_t strb;

  cmd_seq_ctrl #(.WordW(WordW)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .wrDat(wrDat),
    .wrData(wrData), .strb(strb)
  );

  cmd_seq_data #(.WordW(WordW)) i_data (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb),
    .cmdStatus(cmdStatus), .execValid(execValid), .execOp(execOp),
    .execWords(execWords), .execCount(execCount), .overflow(overflow)
  );

  // R10: an execution strobe follows a register write
  a_r10_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> $past(wrCmd || wrDat));

  // R2: only opcodes below 10 ever execute
  a_r2_op_range: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> execOp < OP_W'(OP_LAST));

  // R3: a data-carrying opcode write reports not enough data
  a_r3_short_status: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && need_words(decode_op(WORD_W'(wrData))) != '0)
      |=> (cmdStatus == WordW'(ST_SHORT) && !execValid));
endmodule

// File: tb/test_cmd_seq.sv
module test_cmd_seq;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrCmd = 1'b0;
  logic         wrDat = 1'b0;
  logic [31:0]  wrData = '0;
  logic [31:0]  cmdStatus;
  logic         execValid;
  logic [3:0]   execOp;
  logic [383:0] execWords;
  logic [3:0]   execCount;
  logic         overflow;

  int checks = 0;
  int errors = 0;

  cmd_seq i_cmd_seq (
    .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .wrDat(wrDat), .wrData(wrData),
    .cmdStatus(cmdStatus), .execValid(execValid), .execOp(execOp),
    .execWords(execWords), .execCount(execCount), .overflow(overflow)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write per cycle; returns on the falling edge after the sampling edge
  task automatic put_cmd(logic [31:0] v);
    @(negedge clk); wrCmd = 1'b1; wrData = v;
    @(negedge clk); wrCmd = 1'b0;
  endtask

  task automatic put_dat(logic [31:0] v);
    @(negedge clk); wrDat = 1'b1; wrData = v;
    @(negedge clk); wrDat = 1'b0;
  endtask

  function automatic logic [31:0] word_at(int i);
    return execWords[i*32 +: 32];
  endfunction

  function automatic logic [31:0] pat(int op, int i);
    return 32'hA000_0000 | (op << 16) | i;
  endfunction

  task automatic t_reset;
    chk("R1 status", cmdStatus, 32'h0);
    chk("R1 execValid", {31'b0, execValid}, 32'h0);
    chk("R1 overflow", {31'b0, overflow}, 32'h0);
  endtask

  task automatic t_zero_len;
    int ops[4] = '{2, 3, 6, 8};
    foreach (ops[k]) begin
      put_cmd(ops[k]);
      chk("R4 fires", {31'b0, execValid}, 32'h1);
      chk("R4 op", {28'b0, execOp}, ops[k]);
      chk("R4 count", {28'b0, execCount}, 32'h0);
      chk("R7 status", cmdStatus, (ops[k] <= 3) ? 32'h1 : 32'h0);
      @(negedge clk);
      chk("R10 one cycle", {31'b0, execValid}, 32'h0);
    end
  endtask

  task automatic t_unknown;
    logic [31:0] vals[4] = '{32'h0, 32'd10, 32'd11, 32'hDEAD_BEE4};
    foreach (vals[k]) begin
      put_cmd(32'd6);          // success, so the fail code is a fresh write
      put_cmd(vals[k]);
      chk("R2 fires", {31'b0, execValid}, 32'h1);
      chk("R2 op", {28'b0, execOp}, 32'h0);
      chk("R2 status", cmdStatus, 32'h1);
    end
  endtask

  task automatic t_collect(int op, int n, logic [31:0] st);
    put_cmd(op);
    chk("R3 short", cmdStatus, 32'hFFFF_FFFF);
    chk("R3 no fire", {31'b0, execValid}, 32'h0);
    for (int i = 0; i < n; i++) begin
      put_dat(pat(op, i));
      if (i < n - 1) begin
        chk("R6 early", {31'b0, execValid}, 32'h0);
        chk("R6 still short", cmdStatus, 32'hFFFF_FFFF);
      end
    end
    chk("R6 fires", {31'b0, execValid}, 32'h1);
    chk("R5 op", {28'b0, execOp}, op);
    chk("R5 count", {28'b0, execCount}, n);
    chk("R7 status", cmdStatus, st);
    for (int i = 0; i < n; i++) chk("R5 word", word_at(i), pat(op, i));
    @(negedge clk);
    chk("R10 one cycle", {31'b0, execValid}, 32'h0);
  endtask

  task automatic t_restart;
    put_cmd(32'd9);
    put_dat(32'h1111_0000);
    put_dat(32'h1111_0001);
    put_cmd(32'd5);
    chk("R3 restart short", cmdStatus, 32'hFFFF_FFFF);
    put_dat(32'h2222_0000);
    put_dat(32'h2222_0001);
    chk("R3 no early fire", {31'b0, execValid}, 32'h0);
    put_dat(32'h2222_0002);
    chk("R3 fires", {31'b0, execValid}, 32'h1);
    chk("R3 op", {28'b0, execOp}, 32'd5);
    chk("R3 count", {28'b0, execCount}, 32'd3);
    chk("R3 word0", word_at(0), 32'h2222_0000);
    chk("R3 word2", word_at(2), 32'h2222_0002);
  endtask

  task automatic t_after_exec;
    put_cmd(32'd8);
    put_dat(32'h5555_AAAA);
    chk("R8 fires", {31'b0, execValid}, 32'h1);
    chk("R8 op", {28'b0, execOp}, 32'h0);
    chk("R8 count", {28'b0, execCount}, 32'h1);
    chk("R8 status", cmdStatus, 32'h1);
    chk("R8 word", word_at(0), 32'h5555_AAAA);
  endtask

  task automatic t_collide;
    put_cmd(32'd5);
    put_dat(32'h3333_0000);
    @(negedge clk); wrCmd = 1'b1; wrDat = 1'b1; wrData = 32'd7;
    @(negedge clk); wrCmd = 1'b0; wrDat = 1'b0;
    chk("R9 cmd wins", cmdStatus, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) put_dat(32'h4444_0000 | i);
    chk("R9 data ignored", {31'b0, execValid}, 32'h0);
    put_dat(32'h4444_0003);
    chk("R9 fires", {31'b0, execValid}, 32'h1);
    chk("R9 op", {28'b0, execOp}, 32'd7);
    chk("R9 word0", word_at(0), 32'h4444_0000);
    chk("R9 status", cmdStatus, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_unknown();
    t_collect(1, 6, 32'h1);
    t_collect(4, 12, 32'h0);
    t_collect(5, 3, 32'h0);
    t_collect(7, 4, 32'h0);
    t_collect(9, 4, 32'h0);
    t_restart();
    t_after_exec();
    t_collide();
    chk("R11 overflow", {31'b0, overflow}, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule